// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block carries out solid-colour rectangle fills and rectangle-to-rectangle copies on a linear framebuffer held in a byte-wide memory. The caller presents one request at a time with a destination origin, a size in pixels and, for a copy, a source origin. The pixel size in bytes (1 to 4) and the screen width in pixels come in as separate inputs. The engine walks the rectangle one byte per memory access and raises a one-cycle acknowledge when the rectangle is finished.

Every finished request records its destination rectangle in a circular dirty-rectangle queue. A display process pops entries in arrival order to learn which areas it must refresh. An invalidate input empties the queue in one cycle, for the case where the display is about to repaint everything anyway. If the queue overflows, the oldest record is replaced by the new one and a sticky flag tells the display to repaint the whole screen. Invalidate clears that flag.

Top module: `rfx_rect_engine`

## Requirements
- R1: Pixel (x, y) starts at byte address pix_bytes*x + pix_bytes*scr_width*y. Pixel bytes are written in ascending address order, and no byte outside the rectangle is touched.
- R2: A fill (req_copy=0) writes byte k of each row (k counted from the row's first byte) with colour byte number (k mod pix_bytes), where colour byte 0 is req_color[7:0], 1 is [15:8], 2 is [23:16] and 3 is [31:24].
- R3: A copy (req_copy=1) whose destination y is greater than its source y gives the same memory result as reading the whole source rectangle before writing any destination byte, even when the two areas overlap.
- R4: A copy whose destination y is at or above its source y, including copies within the same rows in either horizontal direction, also gives that overlap-safe result.
- R5: A request with zero width or zero height makes no memory writes, and it still finishes, acknowledges and records its rectangle.
- R6: req_ready is high only while idle. A request is accepted on a clock edge with req_valid and req_ready both high, req_ready drops in the next cycle, and req_done is a single-cycle pulse for each request.
- R7: Each finished request adds its destination (x, y, w, h) to the dirty queue. Entries come out on dq_x/dq_y/dq_w/dq_h in completion order while dq_valid is high, and each dq_pop advances to the next entry.
- R8: One cycle of invalidate removes every entry pending at that edge, so dq_valid is low in the next cycle unless a request finishes in the same cycle.
- R9: The queue holds Q_DEPTH (default 512) entries. A push into a full queue drops the oldest entry and sets redraw_all, which stays high until an invalidate.
- R10: The memory port never reads and writes in the same cycle and is silent while idle. Read data is expected one cycle after mem_rd_en.
- R11: After reset the engine is idle (req_ready=1, req_done=0), the queue is empty and redraw_all is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_copy | input | 1 | 1 = copy, 0 = fill |
| req_color | input | 32 | Fill colour, little-endian bytes |
| req_sx | input | COORD_W | Copy source x |
| req_sy | input | COORD_W | Copy source y |
| req_dx | input | COORD_W | Destination x |
| req_dy | input | COORD_W | Destination y |
| req_w | input | COORD_W | Width in pixels |
| req_h | input | COORD_W | Height in pixels |
| pix_bytes | input | 3 | Bytes per pixel, 1 to 4 |
| scr_width | input | COORD_W | Screen width in pixels |
| req_ready | output | 1 | Engine idle, request accepted |
| req_done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 8 | Memory write data |
| dq_pop | input | 1 | Consume the head dirty entry |
| invalidate | input | 1 | Drop all pending dirty entries and clear redraw_all |
| dq_valid | output | 1 | Dirty queue not empty |
| dq_x | output | COORD_W | Head entry x |
| dq_y | output | COORD_W | Head entry y |
| dq_w | output | COORD_W | Head entry width |
| dq_h | output | COORD_W | Head entry height |
| redraw_all | output | 1 | Queue overflowed, repaint whole screen |

## Verification
Fills run with each pixel size from 1 to 4. The 3-byte case separates a true modulo rotation of colour bytes from a rotation over a power-of-two lane mask. Copies are run against a model that gathers the whole source first. The bench uses overlapping rectangles that shift down, shift up, and slide left or right within the same rows, so a wrong row order or a wrong byte order inside a row shows up as corrupted bytes. Zero-width and zero-height requests check for an acknowledge and a queue entry with no writes. A run of one more request than the queue can hold, followed by a full drain, shows whether the oldest entry, and only that entry, was replaced.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_CWR,
    ST_FIN
  } walk_st_e;

  // Byte address of a pixel in a linear framebuffer.
  function automatic logic [31:0] pix_addr(input logic [31:0] x, input logic [31:0] y,
                                           input logic [31:0] bypp, input logic [31:0] width);
    return bypp * x + bypp * width * y;
  endfunction

  // Ascending or descending walk over 0..last.
  function automatic logic [31:0] walk_index(input logic [31:0] i, input logic [31:0] last,
                                             input logic desc);
    return desc ? (last - i) : i;
  endfunction

  // Pick one little-endian byte of a 32-bit colour word.
  function automatic logic [7:0] color_lane(input logic [31:0] c, input logic [1:0] lane);
    return c[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/rfx_walker.sv
module rfx_walker #(
  parameter int CW = 12,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_copy,
  input  logic [31:0]   req_color,
  input  logic [CW-1:0] req_sx,
  input  logic [CW-1:0] req_sy,
  input  logic [CW-1:0] req_dx,
  input  logic [CW-1:0] req_dy,
  input  logic [CW-1:0] req_w,
  input  logic [CW-1:0] req_h,
  input  logic [2:0]    pix_bytes,
  input  logic [CW-1:0] scr_width,
  output logic          req_ready,
  output logic          req_done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic [4*CW-1:0] push_rect
);
  import rfx_pkg::*;

  localparam int KW = CW + 2;

  walk_st_e      st;
  logic          op_copy;
  logic [31:0]   color;
  logic [CW-1:0] sx, sy, dx, dy, w, h, width, row;
  logic [KW-1:0] k;
  logic [2:0]    bypp;
  logic [1:0]    phase;
  logic          row_desc, byte_desc;

  logic [31:0]   wb_last, cur_row, cur_b;
  logic          accept, advance, byte_last, row_last, empty_req;

  // Walk positions: row order and in-row byte order chosen at accept.
  assign wb_last  = 32'(w) * 32'(bypp) - 32'd1;
  assign cur_row  = walk_index(32'(row), 32'(h) - 32'd1, row_desc);
  assign cur_b    = walk_index(32'(k), wb_last, byte_desc);

  assign accept    = (st == ST_IDLE) && req_valid;
  assign empty_req = (req_w == '0) || (req_h == '0);
  assign advance   = ((st == ST_STEP) && !op_copy) || (st == ST_CWR);
  assign byte_last = (32'(k) == wb_last);
  assign row_last  = (32'(row) == 32'(h) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_copy   <= 1'b0;
      color     <= '0;
      sx        <= '0;
      sy        <= '0;
      dx        <= '0;
      dy        <= '0;
      w         <= '0;
      h         <= '0;
      width     <= '0;
      bypp      <= 3'd1;
      row       <= '0;
      k         <= '0;
      phase     <= '0;
      row_desc  <= 1'b0;
      byte_desc <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            op_copy   <= req_copy;
            color     <= req_color;
            sx        <= req_sx;
            sy        <= req_sy;
            dx        <= req_dx;
            dy        <= req_dy;
            w         <= req_w;
            h         <= req_h;
            width     <= scr_width;
            bypp      <= pix_bytes;
            row       <= '0;
            k         <= '0;
            phase     <= '0;
            row_desc  <= req_copy && (req_dy > req_sy);
            byte_desc <= req_copy && (req_dx > req_sx);
            st        <= empty_req ? ST_FIN : ST_STEP;
          end
        end
        ST_STEP: if (op_copy) st <= ST_CWR;
        ST_CWR:  st <= ST_STEP;
        default: st <= ST_IDLE;
      endcase

      if (advance) begin
        if (byte_last) begin
          k     <= '0;
          phase <= '0;
          if (row_last) st <= ST_FIN;
          else          row <= row + CW'(1);
        end else begin
          k     <= k + KW'(1);
          phase <= ({1'b0, phase} == bypp - 3'd1) ? 2'd0 : phase + 2'd1;
        end
      end
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign req_done    = (st == ST_FIN);
  assign mem_rd_en   = (st == ST_STEP) && op_copy;
  assign mem_rd_addr = AW'(pix_addr(32'(sx), 32'(sy) + cur_row, 32'(bypp), 32'(width)) + cur_b);
  assign mem_wr_en   = advance;
  assign mem_wr_addr = AW'(pix_addr(32'(dx), 32'(dy) + cur_row, 32'(bypp), 32'(width)) + cur_b);
  assign mem_wr_data = op_copy ? mem_rd_data : color_lane(color, phase);
  assign push_rect   = {dx, dy, w, h};

endmodule

// File: rtl/rfx_dirtyq.sv
module rfx_dirtyq #(
  parameter int CW    = 12,
  parameter int DEPTH = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [4*CW-1:0] push_rect,
  input  logic            pop,
  input  logic            invalidate,
  output logic            valid,
  output logic [4*CW-1:0] head_rect,
  output logic            redraw_all
);
  localparam int IW = $clog2(DEPTH);
  localparam int EW = 4 * CW;

  logic [EW-1:0] slots [DEPTH];
  logic [IW:0]   rd_ptr, wr_ptr, count;
  logic          full, pop_eff, overwrite;

  assign count     = wr_ptr - rd_ptr;
  assign full      = (count == (IW+1)'(DEPTH));
  assign valid     = (count != '0);
  assign pop_eff   = pop && valid && !invalidate;
  assign overwrite = push && full && !pop_eff && !invalidate;
  assign head_rect = slots[rd_ptr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr[IW-1:0]] <= push_rect;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      redraw_all <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + (IW+1)'(1);
      if (invalidate)                rd_ptr <= wr_ptr;
      else if (pop_eff || overwrite) rd_ptr <= rd_ptr + (IW+1)'(1);
      if (invalidate)     redraw_all <= 1'b0;
      else if (overwrite) redraw_all <= 1'b1;
    end
  end

endmodule

// File: rtl/rfx_rect_engine.sv
module rfx_rect_engine #(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 24,
  parameter int Q_DEPTH = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_copy,
  input  logic [31:0]        req_color,
  input  logic [COORD_W-1:0] req_sx,
  input  logic [COORD_W-1:0] req_sy,
  input  logic [COORD_W-1:0] req_dx,
  input  logic [COORD_W-1:0] req_dy,
  input  logic [COORD_W-1:0] req_w,
  input  logic [COORD_W-1:0] req_h,
  input  logic [2:0]         pix_bytes,
  input  logic [COORD_W-1:0] scr_width,
  output logic               req_ready,
  output logic               req_done,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [7:0]         mem_wr_data,
  input  logic               dq_pop,
  input  logic               invalidate,
  output logic               dq_valid,
  output logic [COORD_W-1:0] dq_x,
  output logic [COORD_W-1:0] dq_y,
  output logic [COORD_W-1:0] dq_w,
  output logic [COORD_W-1:0] dq_h,
  output logic               redraw_all
);
  localparam int RW = 4 * COORD_W;

  logic [RW-1:0] push_rect, head_rect;

  rfx_walker #(.CW(COORD_W), .AW(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_copy(req_copy), .req_color(req_color),
    .req_sx(req_sx), .req_sy(req_sy), .req_dx(req_dx), .req_dy(req_dy),
    .req_w(req_w), .req_h(req_h), .pix_bytes(pix_bytes), .scr_width(scr_width),
    .req_ready(req_ready), .req_done(req_done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .push_rect(push_rect)
  );

  rfx_dirtyq #(.CW(COORD_W), .DEPTH(Q_DEPTH)) u_dirtyq (
    .clk(clk), .rst_n(rst_n),
    .push(req_done), .push_rect(push_rect),
    .pop(dq_pop), .invalidate(invalidate),
    .valid(dq_valid), .head_rect(head_rect), .redraw_all(redraw_all)
  );

  assign {dq_x, dq_y, dq_w, dq_h} = head_rect;

endmodule

// File: rtl/rfx_rect_engine_chk.sv
module rfx_rect_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_done,
  input logic mem_rd_en,
  input logic mem_wr_en,
  input logic invalidate,
  input logic dq_valid,
  input logic redraw_all
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_en && !mem_wr_en));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidate && !req_done) |=> !dq_valid);

  // R9
  redraw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redraw_all) |-> $past(req_done));

  // R9
  redraw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> !redraw_all);

endmodule

bind rfx_rect_engine rfx_rect_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_done(req_done), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .invalidate(invalidate), .dq_valid(dq_valid), .redraw_all(redraw_all)
);

// File: tb/rfx_rect_engine_bench.sv
`timescale 1ns/1ps
module rfx_rect_engine_bench;
  localparam int CW = 12;
  localparam int AW = 24;
  localparam int QD = 512;
  localparam int SW = 16;
  localparam int MS = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_copy = 1'b0;
  logic [31:0] req_color = '0;
  logic [CW-1:0] req_sx = '0, req_sy = '0, req_dx = '0, req_dy = '0, req_w = '0, req_h = '0;
  logic [2:0] pix_bytes = 3'd1;
  logic [CW-1:0] scr_width = CW'(SW);
  logic req_ready, req_done, mem_rd_en, mem_wr_en, dq_valid, redraw_all;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data;
  logic dq_pop = 1'b0, invalidate = 1'b0;
  logic [CW-1:0] dq_x, dq_y, dq_w, dq_h;

  always #10 clk = ~clk;

  rfx_rect_engine #(.COORD_W(CW), .ADDR_W(AW), .Q_DEPTH(QD)) u_rfx_rect_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_copy(req_copy),
    .req_color(req_color), .req_sx(req_sx), .req_sy(req_sy), .req_dx(req_dx),
    .req_dy(req_dy), .req_w(req_w), .req_h(req_h), .pix_bytes(pix_bytes),
    .scr_width(scr_width), .req_ready(req_ready), .req_done(req_done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .dq_pop(dq_pop), .invalidate(invalidate), .dq_valid(dq_valid),
    .dq_x(dq_x), .dq_y(dq_y), .dq_w(dq_w), .dq_h(dq_h), .redraw_all(redraw_all)
  );

  // Framebuffer model with one-cycle read latency.
  logic [7:0] dmem [MS];
  logic [7:0] rmem [MS];
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MS; i++) dmem[i] <= 8'(i * 7 + 3);
    end else if (mem_wr_en) begin
      dmem[mem_wr_addr[11:0]] <= mem_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rd_data <= dmem[mem_rd_addr[11:0]];
  end

  int n_chk = 0, n_fail = 0;
  logic [4*CW-1:0] exp_q [$];
  bit mon_en = 1'b1;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: drains the dirty queue and compares in order (R7).
  always @(negedge clk) begin
    if (rst_n && mon_en && dq_valid) begin
      logic [4*CW-1:0] got, want;
      got = {dq_x, dq_y, dq_w, dq_h};
      if (exp_q.size() == 0) begin
        chk("R7 unexpected dirty entry", 1'b0, longint'(got), 0);
      end else begin
        want = exp_q.pop_front();
        chk("R7 dirty entry order", got == want, longint'(got), longint'(want));
      end
      dq_pop = 1'b1;
    end else begin
      dq_pop = 1'b0;
    end
  end

  function automatic int paddr(input int x, input int y, input int bp);
    return bp * x + bp * SW * y;
  endfunction

  // Reference: whole source gathered before any write, so overlap is handled.
  task automatic ref_apply(input bit cp, input logic [31:0] col, input int sx, input int sy,
                           input int dx, input int dy, input int w, input int h, input int bp);
    byte unsigned tmp [$];
    for (int r = 0; r < h; r++)
      for (int b = 0; b < w * bp; b++)
        tmp.push_back(cp ? rmem[paddr(sx, sy + r, bp) + b] : col[8 * (b % bp) +: 8]);
    for (int r = 0; r < h; r++)
      for (int b = 0; b < w * bp; b++)
        rmem[paddr(dx, dy + r, bp) + b] = tmp[r * w * bp + b];
  endtask

  task automatic run_op(input string tag, input bit cp, input logic [31:0] col,
                        input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input int bp, input bit cmp);
    int start, guard, bad, first;
    ref_apply(cp, col, sx, sy, dx, dy, w, h, bp);
    exp_q.push_back({CW'(dx), CW'(dy), CW'(w), CW'(h)});
    @(negedge clk);
    start = wr_cnt;
    pix_bytes = 3'(bp); req_copy = cp; req_color = col;
    req_sx = CW'(sx); req_sy = CW'(sy); req_dx = CW'(dx); req_dy = CW'(dy);
    req_w = CW'(w); req_h = CW'(h); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (cmp) chk({tag, " R6 busy after accept"}, !req_ready, req_ready, 0);
    guard = 0;
    while (!req_done && guard < 20000) begin @(negedge clk); guard++; end
    chk({tag, " R6 done seen"}, req_done, req_done, 1);
    @(negedge clk);
    if (cmp) begin
      chk({tag, " R6 done single pulse"}, !req_done, req_done, 0);
      chk({tag, " R1 R5 write count"}, (wr_cnt - start) == w * h * bp, wr_cnt - start, w * h * bp);
      bad = 0; first = -1;
      for (int i = 0; i < MS; i++)
        if (dmem[i] !== rmem[i]) begin bad++; if (first < 0) first = i; end
      if (first < 0) first = 0;
      chk({tag, " memory image"}, bad == 0, dmem[first], rmem[first]);
    end
  endtask

  initial begin
    for (int i = 0; i < MS; i++) rmem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", req_ready, req_ready, 1);
    chk("R11 done", !req_done, req_done, 0);
    chk("R11 queue empty", !dq_valid, dq_valid, 0);
    chk("R11 redraw_all", !redraw_all, redraw_all, 0);

    // R1 R2 fills at each pixel size; 3 bytes checks true modulo rotation
    run_op("R1 R2 fill bypp1", 1'b0, 32'h000000A1, 0, 0, 2, 3, 5, 2, 1, 1'b1);
    run_op("R2 fill bypp2", 1'b0, 32'h00001234, 0, 0, 4, 5, 3, 3, 2, 1'b1);
    run_op("R2 fill bypp3", 1'b0, 32'h00C0FFEE, 0, 0, 3, 8, 4, 2, 3, 1'b1);
    run_op("R2 fill bypp4", 1'b0, 32'hDEADBEEF, 0, 0, 9, 2, 2, 2, 4, 1'b1);
    // R3 overlapping copy moving down
    run_op("R3 copy down", 1'b1, 32'h0, 0, 0, 1, 2, 6, 5, 2, 1'b1);
    // R4 overlapping copy moving up, then same-row right and left
    run_op("R4 copy up", 1'b1, 32'h0, 1, 4, 0, 1, 6, 5, 2, 1'b1);
    run_op("R4 copy same row right", 1'b1, 32'h0, 0, 10, 2, 10, 8, 3, 3, 1'b1);
    run_op("R4 copy same row left", 1'b1, 32'h0, 3, 14, 1, 14, 9, 2, 4, 1'b1);
    // R5 empty rectangles
    run_op("R5 fill zero width", 1'b0, 32'hFFFFFFFF, 0, 0, 5, 5, 0, 3, 2, 1'b1);
    run_op("R5 fill zero height", 1'b0, 32'hFFFFFFFF, 0, 0, 5, 5, 3, 0, 2, 1'b1);
    run_op("R5 copy zero width", 1'b1, 32'h0, 1, 1, 7, 7, 0, 2, 1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 queue drained", exp_q.size() == 0 && !dq_valid, exp_q.size(), 0);

    // R8 invalidate drops pending entries
    mon_en = 1'b0;
    run_op("R8 fill a", 1'b0, 32'h11, 0, 0, 0, 0, 1, 1, 1, 1'b1);
    run_op("R8 fill b", 1'b0, 32'h22, 0, 0, 1, 0, 1, 1, 1, 1'b1);
    chk("R8 entries pending", dq_valid, dq_valid, 1);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    chk("R8 queue empty after invalidate", !dq_valid, dq_valid, 0);
    exp_q.delete();

    // R9 overflow: one more than the depth; the first entry is lost
    for (int i = 0; i <= QD; i++)
      run_op("R9 fill", 1'b0, 32'h0, 0, 0, i, 1, 0, 0, 1, 1'b0);
    void'(exp_q.pop_front());
    chk("R9 redraw_all set", redraw_all, redraw_all, 1);
    chk("R9 head is second entry", dq_x == CW'(1), dq_x, 1);
    mon_en = 1'b1;
    for (int g = 0; g < 3 * QD && exp_q.size() != 0; g++) @(negedge clk);
    @(negedge clk);
    chk("R9 drained all", exp_q.size() == 0 && !dq_valid, exp_q.size(), 0);
    chk("R9 redraw_all held", redraw_all, redraw_all, 1);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    chk("R9 redraw_all cleared", !redraw_all, redraw_all, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule